// File: doc/BRIEF.md
# Flash Command Chunking Sequencer

This block sits between a requester and a serial flash transaction engine. A request arrives as a byte stream. The first byte is the opcode, followed by any address bytes, an optional dummy byte and any write data. The read length is presented beside the opcode byte. The block decodes the opcode to learn how many address, transmit and receive bytes the command needs. It then turns the request into engine transactions that each move at most four data bytes, and advances the flash address after every piece.

Program requests need extra handling. Before each piece the block sends a write-enable command. After each piece it keeps polling the device status until the busy flag clears, and only then starts the next piece. Read requests are split the same way but get no extra commands. A fast read is carried out as a plain read, and its dummy byte is thrown away. Read data comes back to the requester as a byte stream. When the request finishes, or is rejected, the block reports completion once with an error flag.

Top module: `flash_piece_seq`

## Requirements
- R1: Opcodes decode as follows. Status read 0x05 returns 1 byte. Identification read 0x9F returns 3 bytes. Write-enable 0x06, write-disable 0x04 and chip erase 0xC7 send only the opcode (transmit count 1). Write-status 0x01 sends its data bytes after the opcode. Read-ID 0xAB sends 3 address bytes and returns 1 byte. Sector erase 0xD8 sends 3 address bytes (transmit count 4).
- R2: Every engine transaction carries at most 4 data bytes. The transmit count is 1 + address bytes + write bytes, and the receive count is 0 to 4. After each piece the address advances by the number of data bytes moved.
- R3: Every program (0x02) piece is preceded by its own write-enable transaction: opcode 0x06, transmit count 1, receive count 0.
- R4: After every program piece the block issues status reads (opcode 0x05, transmit 1, receive 1). It repeats them until bit 0 of the returned low byte is 0. Only then may the next write-enable or the completion follow.
- R5: Read requests (0x03) are split into pieces of up to 4 bytes, with no write-enable and no status read inserted.
- R6: A fast read (0x0B) takes 3 address bytes and then one dummy byte. The dummy byte is discarded, and the request runs as opcode 0x03 with transmit count 4.
- R7: Address bytes arrive most significant first and form a 24-bit address. This address appears on the engine address output.
- R8: A request is rejected without any engine transaction, and completion is reported with the error flag set, in any of these cases: the opcode is unknown; write-data bytes arrive while the read length is nonzero; the stream ends inside the address or dummy bytes. Bytes up to the one marked last are drained.
- R9: Completion is pulsed exactly once per request, with the error flag clear, after the final piece (including its status polling for a program).
- R10: Read data bytes leave in address order, taking the low byte of each returned word first, under a valid/ready handshake. A byte stays stable while it waits.
- R11: After reset the request input is ready and no transaction or completion is pending. The request input is held off while engine transactions are outstanding.
- R12: An engine request, once raised, holds its opcode, address and counts stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request byte valid |
| in_ready | output | 1 | Request byte accepted this cycle when valid |
| in_byte | input | 8 | Request byte: opcode, address, dummy, write data |
| in_last | input | 1 | Marks the final byte of a request |
| in_rdlen | input | LEN_W | Read length for 0x03/0x0B, sampled with the opcode byte |
| eng_valid | output | 1 | Engine transaction request |
| eng_ready | input | 1 | Engine accepts the request |
| eng_op | output | 8 | Opcode sent by the engine |
| eng_addr | output | ADDR_W | Flash address for this piece |
| eng_txcnt | output | TXC_W | Transmit bytes including opcode |
| eng_rxcnt | output | RXC_W | Receive bytes |
| eng_wdata | output | 8*MAX_PIECE | Write bytes, first byte in bits 7:0 |
| eng_done | input | 1 | Engine finished the accepted transaction |
| eng_rdata | input | 8*MAX_PIECE | Received bytes, first byte in bits 7:0 |
| rd_valid | output | 1 | Read data byte valid |
| rd_ready | input | 1 | Requester takes the read byte |
| rd_byte | output | 8 | Read data byte |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request was rejected |

## Verification
The hardest situation to reach is a program request that crosses several pieces while the device stays busy. Here every piece boundary has to wait through repeated status reads before the next write-enable. The engine model in the bench reports busy for the first two status reads after each program piece and stalls its ready signal on a fixed pattern. Each piece therefore sees a multi-poll loop and held requests. Read requests are run with a throttled read-ready, so that the emitter stalls in the middle of a word between pieces.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_WRSR   = 8'h01;
  localparam logic [7:0] OPC_READ   = 8'h03;
  localparam logic [7:0] OPC_FREAD  = 8'h0B;
  localparam logic [7:0] OPC_PROG   = 8'h02;
  localparam logic [7:0] OPC_SERASE = 8'hD8;
  localparam logic [7:0] OPC_CERASE = 8'hC7;
  localparam logic [7:0] OPC_RDID   = 8'hAB;
  localparam logic [7:0] OPC_JEDEC  = 8'h9F;

  typedef struct packed {
    logic       known;
    logic [1:0] addr_n;
    logic       dummy;
    logic [2:0] fix_rx;
    logic       rx_len;
    logic       takes_wr;
    logic       is_prog;
  } op_info_t;

  typedef enum logic [2:0] {
    ST_OP, ST_HDR, ST_FILL, ST_DRAIN, ST_WREN, ST_XFER, ST_EMIT, ST_POLL
  } seq_st_t;

  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t r;
    r = '0;
    r.known = 1'b1;
    case (op)
      OPC_WREN, OPC_WRDI, OPC_CERASE: ;
      OPC_JEDEC:  r.fix_rx = 3'd3;
      OPC_RDSR:   r.fix_rx = 3'd1;
      OPC_WRSR:   r.takes_wr = 1'b1;
      OPC_RDID:   begin r.addr_n = 2'd3; r.fix_rx = 3'd1; end
      OPC_SERASE: r.addr_n = 2'd3;
      OPC_READ:   begin r.addr_n = 2'd3; r.rx_len = 1'b1; end
      OPC_FREAD:  begin r.addr_n = 2'd3; r.rx_len = 1'b1; r.dummy = 1'b1; end
      OPC_PROG:   begin r.addr_n = 2'd3; r.takes_wr = 1'b1; r.is_prog = 1'b1; end
      default:    r.known = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fsp_opdec.sv
module fsp_opdec
  import fsp_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  always_comb info = decode_op(op);
endmodule

// File: rtl/fsp_rdemit.sv
module fsp_rdemit #(
  parameter int MAX_PIECE = 4,
  localparam int RXC_W = $clog2(MAX_PIECE + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [8*MAX_PIECE-1:0] load_word,
  input  logic [RXC_W-1:0]       load_cnt,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [7:0]             out_byte,
  output logic                   busy
);
  logic [8*MAX_PIECE-1:0] word_q, word_d;
  logic [RXC_W-1:0]       left_q, left_d;

  assign out_valid = (left_q != '0);
  assign out_byte  = word_q[7:0];
  assign busy      = out_valid;

  always_comb begin
    word_d = word_q;
    left_d = left_q;
    if (load) begin
      word_d = load_word;
      left_d = load_cnt;
    end else if (out_valid && out_ready) begin
      word_d = word_q >> 8;
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      left_q <= '0;
    end else begin
      word_q <= word_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/flash_piece_seq.sv
module flash_piece_seq
  import fsp_pkg::*;
#(
  parameter int MAX_PIECE = 4,
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  localparam int RXC_W    = $clog2(MAX_PIECE + 1),
  localparam int TXC_W    = $clog2(MAX_PIECE + 5),
  localparam int DW       = 8 * MAX_PIECE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic              in_last,
  input  logic [LEN_W-1:0]  in_rdlen,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [7:0]        eng_op,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [TXC_W-1:0]  eng_txcnt,
  output logic [RXC_W-1:0]  eng_rxcnt,
  output logic [DW-1:0]     eng_wdata,
  input  logic              eng_done,
  input  logic [DW-1:0]     eng_rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_byte,
  output logic              done_valid,
  output logic              done_err
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  seq_st_t              state_q, state_d;
  logic [7:0]           op_q, op_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [1:0]           alft_q, alft_d;
  logic                 dmy_q, dmy_d;
  logic [LEN_W-1:0]     rxl_q, rxl_d;
  logic                 rdnz_q, rdnz_d;
  logic                 wend_q, wend_d;
  logic [RXC_W-1:0]     nb_q, nb_d;
  logic [DW-1:0]        wbuf_q, wbuf_d;
  logic                 pend_q, pend_d;
  logic                 done_q, done_d;
  logic                 err_q, err_d;

  logic [7:0]       dec_op;
  op_info_t         info;
  logic             take, accept, fin;
  logic [RXC_W-1:0] rxp;
  logic             emit_load, emit_busy;
  seq_st_t          issue_st;

  assign dec_op = (state_q == ST_OP) ? in_byte : op_q;

  fsp_opdec u_dec (.op(dec_op), .info(info));

  assign in_ready  = (state_q == ST_OP) || (state_q == ST_HDR) ||
                     (state_q == ST_FILL) || (state_q == ST_DRAIN);
  assign take      = in_valid && in_ready;
  assign eng_valid = ((state_q == ST_WREN) || (state_q == ST_XFER) ||
                      (state_q == ST_POLL)) && !pend_q;
  assign accept    = eng_valid && eng_ready;
  assign fin       = pend_q && eng_done;
  assign issue_st  = info.is_prog ? ST_WREN : ST_XFER;
  assign rxp       = (rxl_q > LEN_W'(MAX_PIECE)) ? RXC_W'(MAX_PIECE) : rxl_q[RXC_W-1:0];

  always_comb begin
    eng_op    = (info.dummy) ? OPC_READ : op_q;
    eng_txcnt = TXC_W'(1) + TXC_W'(info.addr_n) + TXC_W'(nb_q);
    eng_rxcnt = rxp;
    if (state_q == ST_WREN) begin
      eng_op    = OPC_WREN;
      eng_txcnt = TXC_W'(1);
      eng_rxcnt = '0;
    end else if (state_q == ST_POLL) begin
      eng_op    = OPC_RDSR;
      eng_txcnt = TXC_W'(1);
      eng_rxcnt = RXC_W'(1);
    end
  end
  assign eng_addr  = addr_q;
  assign eng_wdata = wbuf_q;

  assign emit_load = (state_q == ST_XFER) && fin && !info.is_prog;

  fsp_rdemit #(.MAX_PIECE(MAX_PIECE)) u_emit (
    .clk(clk), .rst_n(core_rst_n), .load(emit_load), .load_word(eng_rdata),
    .load_cnt(rxp), .out_ready(rd_ready), .out_valid(rd_valid),
    .out_byte(rd_byte), .busy(emit_busy)
  );

  assign done_valid = done_q;
  assign done_err   = err_q;

  always_comb begin
    state_d = state_q;  op_d   = op_q;   addr_d = addr_q;  alft_d = alft_q;
    dmy_d   = dmy_q;    rxl_d  = rxl_q;  rdnz_d = rdnz_q;  wend_d = wend_q;
    nb_d    = nb_q;     wbuf_d = wbuf_q; pend_d = pend_q;
    done_d  = 1'b0;     err_d  = 1'b0;

    if (accept) pend_d = 1'b1;

    case (state_q)
      ST_OP: if (take) begin
        op_d   = in_byte;
        addr_d = '0;
        alft_d = info.addr_n;
        dmy_d  = info.dummy;
        rxl_d  = info.rx_len ? in_rdlen : LEN_W'(info.fix_rx);
        rdnz_d = (in_rdlen != '0);
        wend_d = in_last;
        nb_d   = '0;
        wbuf_d = '0;
        if (!info.known) begin
          if (in_last) begin state_d = ST_OP; done_d = 1'b1; err_d = 1'b1; end
          else state_d = ST_DRAIN;
        end else if (in_last) begin
          if ((info.addr_n != 2'd0) || info.dummy) begin
            done_d = 1'b1; err_d = 1'b1;
          end else state_d = issue_st;
        end else if ((info.addr_n != 2'd0) || info.dummy) begin
          state_d = ST_HDR;
        end else if (!info.takes_wr || (in_rdlen != '0)) begin
          state_d = ST_DRAIN;
        end else state_d = ST_FILL;
      end

      ST_HDR: if (take) begin
        if (alft_q != 2'd0) begin
          addr_d = {addr_q[ADDR_W-9:0], in_byte};
          alft_d = alft_q - 2'd1;
        end else dmy_d = 1'b0;
        if (((alft_q == 2'd1) && !dmy_q) || (alft_q == 2'd0)) begin
          if (in_last) begin
            wend_d  = 1'b1;
            state_d = issue_st;
          end else if (!info.takes_wr || rdnz_q) state_d = ST_DRAIN;
          else state_d = ST_FILL;
        end else if (in_last) begin
          state_d = ST_OP; done_d = 1'b1; err_d = 1'b1;
        end
      end

      ST_FILL: if (take) begin
        wbuf_d[{nb_q, 3'b000} +: 8] = in_byte;
        nb_d = nb_q + 1'b1;
        if (in_last) wend_d = 1'b1;
        if (in_last || (nb_q == RXC_W'(MAX_PIECE - 1))) state_d = issue_st;
      end

      ST_DRAIN: if (take && in_last) begin
        state_d = ST_OP; done_d = 1'b1; err_d = 1'b1;
      end

      ST_WREN: if (fin) begin
        pend_d  = 1'b0;
        state_d = ST_XFER;
      end

      ST_XFER: if (fin) begin
        pend_d  = 1'b0;
        addr_d  = addr_q + ADDR_W'(nb_q) + ADDR_W'(rxp);
        rxl_d   = rxl_q - LEN_W'(rxp);
        state_d = info.is_prog ? ST_POLL : ST_EMIT;
      end

      default: ;
    endcase

    // advance after a finished piece (emit drained, or poll reads idle)
    if (((state_q == ST_EMIT) && !emit_busy) ||
        ((state_q == ST_POLL) && fin && !eng_rdata[0])) begin
      pend_d = 1'b0;
      if (!wend_q) begin
        state_d = ST_FILL; nb_d = '0; wbuf_d = '0;
      end else if (rxl_q != '0) state_d = ST_XFER;
      else begin
        state_d = ST_OP; done_d = 1'b1;
      end
    end else if ((state_q == ST_POLL) && fin) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_OP; op_q   <= '0; addr_q <= '0; alft_q <= '0;
      dmy_q   <= 1'b0;  rxl_q  <= '0; rdnz_q <= 1'b0; wend_q <= 1'b0;
      nb_q    <= '0;    wbuf_q <= '0; pend_q <= 1'b0;
      done_q  <= 1'b0;  err_q  <= 1'b0;
    end else begin
      state_q <= state_d; op_q   <= op_d;   addr_q <= addr_d; alft_q <= alft_d;
      dmy_q   <= dmy_d;   rxl_q  <= rxl_d;  rdnz_q <= rdnz_d; wend_q <= wend_d;
      nb_q    <= nb_d;    wbuf_q <= wbuf_d; pend_q <= pend_d;
      done_q  <= done_d;  err_q  <= err_d;
    end
  end

endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int MAX_PIECE = 4,
  parameter int ADDR_W    = 24,
  localparam int RXC_W    = $clog2(MAX_PIECE + 1),
  localparam int TXC_W    = $clog2(MAX_PIECE + 5)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              eng_valid,
  input logic              eng_ready,
  input logic [7:0]        eng_op,
  input logic [ADDR_W-1:0] eng_addr,
  input logic [TXC_W-1:0]  eng_txcnt,
  input logic [RXC_W-1:0]  eng_rxcnt,
  input logic              eng_done,
  input logic [7:0]        eng_rdata_lo,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_byte,
  input logic              done_valid
);
  logic       acc;
  logic [7:0] last_op_q;
  logic       poll_busy_q;

  assign acc = eng_valid && eng_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op_q   <= 8'h00;
      poll_busy_q <= 1'b0;
    end else begin
      if (acc) last_op_q <= eng_op;
      if (eng_done && (last_op_q == 8'h05)) poll_busy_q <= eng_rdata_lo[0];
    end
  end

  // R12
  eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid && !eng_ready |=> eng_valid && $stable(eng_op) && $stable(eng_addr)
      && $stable(eng_txcnt) && $stable(eng_rxcnt));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_byte));

  // R11
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> !in_ready);

  // R2
  piece_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> (int'(eng_rxcnt) <= MAX_PIECE) && (int'(eng_txcnt) <= MAX_PIECE + 4));

  // R3
  wren_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (eng_op == 8'h02) |-> (last_op_q == 8'h06));

  // R4
  poll_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (last_op_q == 8'h02) |-> (eng_op == 8'h05) && (eng_txcnt == 1) && (eng_rxcnt == 1));

  // R4
  poll_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (eng_op == 8'h06) && (last_op_q == 8'h05) |-> !poll_busy_q);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> in_ready && !eng_valid);

endmodule

bind flash_piece_seq fsp_chk #(.MAX_PIECE(MAX_PIECE), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .eng_valid(eng_valid),
  .eng_ready(eng_ready), .eng_op(eng_op), .eng_addr(eng_addr),
  .eng_txcnt(eng_txcnt), .eng_rxcnt(eng_rxcnt), .eng_done(eng_done),
  .eng_rdata_lo(eng_rdata[7:0]), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_byte(rd_byte), .done_valid(done_valid)
);

// File: tb/flash_piece_seq_test.sv
module flash_piece_seq_test;

  localparam int MAXP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last, in_ready;
  logic [7:0]  in_byte;
  logic [15:0] in_rdlen;
  logic        eng_valid, eng_ready, eng_done;
  logic [7:0]  eng_op;
  logic [23:0] eng_addr;
  logic [3:0]  eng_txcnt;
  logic [2:0]  eng_rxcnt;
  logic [31:0] eng_wdata, eng_rdata;
  logic        rd_valid, rd_ready, done_valid, done_err;
  logic [7:0]  rd_byte;

  always #10 clk = ~clk;

  flash_piece_seq uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_last(in_last), .in_rdlen(in_rdlen),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_txcnt(eng_txcnt), .eng_rxcnt(eng_rxcnt),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_rdata(eng_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_byte(rd_byte),
    .done_valid(done_valid), .done_err(done_err)
  );

  typedef struct {
    logic [7:0]  op;
    logic [23:0] addr;
    bit          chk_a;
    int          tx;
    int          rx;
    logic [31:0] wd;
    string       req;
  } txn_t;

  txn_t        exp_txn[$];
  logic [7:0]  exp_rd[$];
  string       exp_rd_req[$];
  bit          exp_done[$];
  logic [7:0]  stim[$];
  int          n_chk = 0, n_fail = 0;
  int          done_seen = 0, done_exp = 0;
  bit          finished = 0;

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_txn(input logic [7:0] op, input logic [23:0] a, input bit ca,
                          input int tx, input int rx, input logic [31:0] wd, input string req);
    txn_t t;
    t.op = op; t.addr = a; t.chk_a = ca; t.tx = tx; t.rx = rx; t.wd = wd; t.req = req;
    exp_txn.push_back(t);
  endtask

  // engine model and transaction monitor
  int          cyc = 0, dtimer = 0, busy_left = 0;
  logic [31:0] resp;
  always @(negedge clk) begin
    if (rst_n) begin
      txn_t t;
      cyc++;
      eng_done = 1'b0;
      if (dtimer > 0) begin
        dtimer--;
        if (dtimer == 0) begin eng_done = 1'b1; eng_rdata = resp; end
      end
      eng_ready = (cyc % 3 != 0);
      if (eng_valid && eng_ready) begin
        if (exp_txn.size() == 0) begin
          check("R8", "unexpected engine op", eng_op, 0);
        end else begin
          t = exp_txn.pop_front();
          check(t.req, "op", eng_op, t.op);
          check(t.req, "txcnt", eng_txcnt, t.tx);
          check(t.req, "rxcnt", eng_rxcnt, t.rx);
          if (t.chk_a) check(t.req, "addr", eng_addr, t.addr);
          if (t.op == 8'h02 || t.op == 8'h01) check(t.req, "wdata", eng_wdata, t.wd);
        end
        resp = 32'h0;
        case (eng_op)
          8'h05: begin resp = (busy_left > 0) ? 32'h03 : 32'h02; if (busy_left > 0) busy_left--; end
          8'h02: busy_left = 2;
          8'h03: resp = {fbyte(eng_addr + 24'd3), fbyte(eng_addr + 24'd2),
                         fbyte(eng_addr + 24'd1), fbyte(eng_addr)};
          8'h9F: resp = 32'h001720C2;
          8'hAB: resp = 32'h00000014;
          default: ;
        endcase
        dtimer = 2;
      end
    end
  end

  // read data monitor
  int rcyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      rcyc++;
      rd_ready = (rcyc % 2 == 0);
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0) check("R10", "unexpected read byte", rd_byte, 0);
        else check(exp_rd_req.pop_front(), "read byte", rd_byte, exp_rd.pop_front());
      end
      if (done_valid) begin
        done_seen++;
        if (exp_done.size() == 0) check("R9", "unexpected completion", 1, 0);
        else check("R9/R8", "done_err", done_err, exp_done.pop_front());
      end
    end
  end

  task automatic run_req(input int rdlen, input bit err);
    exp_done.push_back(err);
    done_exp++;
    for (int i = 0; i < stim.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_byte = stim[i]; in_last = (i == stim.size() - 1);
      in_rdlen = 16'(rdlen);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    while (done_seen < done_exp) @(negedge clk);
    stim.delete();
  endtask

  task automatic do_prog(input logic [23:0] a, input int n, input logic [7:0] seed);
    logic [23:0] pa;
    int left;
    stim.push_back(8'h02);
    stim.push_back(a[23:16]); stim.push_back(a[15:8]); stim.push_back(a[7:0]);
    for (int i = 0; i < n; i++) stim.push_back(seed + 8'(i));
    pa = a; left = n;
    for (int p = 0; p < n; p += MAXP) begin
      int k;
      logic [31:0] wd;
      k = (left > MAXP) ? MAXP : left;
      wd = 32'h0;
      for (int j = 0; j < k; j++) wd[8*j +: 8] = seed + 8'(p + j);
      push_txn(8'h06, 24'h0, 0, 1, 0, 0, "R3");
      push_txn(8'h02, pa, 1, 4 + k, 0, wd, "R2/R7");
      for (int q = 0; q < 3; q++) push_txn(8'h05, 24'h0, 0, 1, 1, 0, "R4");
      pa += 24'(k); left -= k;
    end
    run_req(0, 0);
  endtask

  task automatic do_read(input bit fast, input logic [23:0] a, input int n);
    logic [23:0] pa;
    int left;
    stim.push_back(fast ? 8'h0B : 8'h03);
    stim.push_back(a[23:16]); stim.push_back(a[15:8]); stim.push_back(a[7:0]);
    if (fast) stim.push_back(8'hFF);
    pa = a; left = n;
    while (left > 0) begin
      int k;
      k = (left > MAXP) ? MAXP : left;
      push_txn(8'h03, pa, 1, 4, k, 0, fast ? "R6" : "R5");
      pa += 24'(k); left -= k;
    end
    for (int i = 0; i < n; i++) begin
      exp_rd.push_back(fbyte(a + 24'(i)));
      exp_rd_req.push_back("R10");
    end
    run_req(n, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      check("R9", "scoreboard txn leftovers", exp_txn.size(), 0);
      check("R10", "scoreboard read leftovers", exp_rd.size(), 0);
      check("R9", "scoreboard done leftovers", exp_done.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_byte = 8'h0; in_rdlen = 16'h0;
    eng_ready = 1'b0; eng_done = 1'b0; eng_rdata = 32'h0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check("R11", "in_ready after reset", in_ready, 1);
    check("R11", "eng_valid after reset", eng_valid, 0);
    check("R11", "rd_valid after reset", rd_valid, 0);
    check("R11", "done_valid after reset", done_valid, 0);

    // R3 R4 R2 R7: ten-byte program crossing a boundary
    do_prog(24'h001FFE, 10, 8'h40);
    // R2 R5 R10: nine-byte read
    do_read(0, 24'h123456, 9);
    // R6: fast read, dummy dropped
    do_read(1, 24'h000100, 5);

    // R1: identification read, 3 bytes
    stim.push_back(8'h9F);
    push_txn(8'h9F, 0, 0, 1, 3, 0, "R1");
    exp_rd.push_back(8'hC2); exp_rd.push_back(8'h20); exp_rd.push_back(8'h17);
    repeat (3) exp_rd_req.push_back("R1");
    run_req(0, 0);
    // R1: status read
    stim.push_back(8'h05);
    push_txn(8'h05, 0, 0, 1, 1, 0, "R1");
    exp_rd.push_back(8'h02); exp_rd_req.push_back("R1");
    run_req(0, 0);
    // R1: opcode-only commands
    stim.push_back(8'h06); push_txn(8'h06, 0, 0, 1, 0, 0, "R1"); run_req(0, 0);
    stim.push_back(8'h04); push_txn(8'h04, 0, 0, 1, 0, 0, "R1"); run_req(0, 0);
    stim.push_back(8'hC7); push_txn(8'hC7, 0, 0, 1, 0, 0, "R1"); run_req(0, 0);
    // R1 R7: sector erase
    stim.push_back(8'hD8); stim.push_back(8'hAB); stim.push_back(8'hCD); stim.push_back(8'hEF);
    push_txn(8'hD8, 24'hABCDEF, 1, 4, 0, 0, "R1"); run_req(0, 0);
    // R1: read-ID with dummy address bytes
    stim.push_back(8'hAB); stim.push_back(0); stim.push_back(0); stim.push_back(0);
    push_txn(8'hAB, 24'h0, 1, 4, 1, 0, "R1");
    exp_rd.push_back(8'h14); exp_rd_req.push_back("R1");
    run_req(0, 0);
    // R1: write-status with one data byte
    stim.push_back(8'h01); stim.push_back(8'h3C);
    push_txn(8'h01, 0, 0, 2, 0, 32'h3C, "R1"); run_req(0, 0);

    // R8: unknown opcode with trailing bytes
    stim.push_back(8'h55); stim.push_back(8'h11); stim.push_back(8'h22);
    run_req(0, 1);
    // R8: read length together with write data
    stim.push_back(8'h03); stim.push_back(0); stim.push_back(0); stim.push_back(8'h10);
    stim.push_back(8'hAA); stim.push_back(8'hBB);
    run_req(4, 1);
    // R8: stream ends inside the address
    stim.push_back(8'h02); stim.push_back(8'h12);
    run_req(0, 1);

    // R9: a single-piece program still completes after its polls
    do_prog(24'h00FFFF, 3, 8'h90);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule